// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command at a time from a small register set. Software writes an opcode register, an address register and a word-wide data buffer. It then writes a configuration word. Setting the start bit in that word launches the command. The sequencer drives one of four active-low chip selects, a serial clock that idles low, and up to four bidirectional I/O lanes with per-lane output enables. The command is made of an opcode phase, then an optional address phase, optional dummy cycles and an optional write or read data phase.

The lane width of the opcode, address and data phases comes from a 3-bit I/O mode field. Modes cover single-lane, dual and quad operation, including variants where the address or opcode phase is also widened. The address length of 3 or 4 bytes is set by a static strap input. Read data is stored back into the same buffer, packed least significant byte first. The start bit reads back as 1 for the whole command, so software can poll it to learn when the command has completed.

Register map (word addresses on `reg_addr_i`): 0x00 configuration, 0x01 opcode (bits 7:0), 0x02 address, and 0x40 plus n for buffer word n.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: Writing the configuration register with bit 0 set while idle starts a command. While the command runs, bit 0 of the configuration register reads as 1. It reads as 0 once the chip select has been released.
- R2: The opcode phase always comes first and sends the 8 opcode bits, most significant first, at the opcode lane width of the I/O mode.
- R3: The I/O mode is taken from configuration bits 19:17, and each code sets the lane widths for opcode, address and data as follows. Code 0 uses one lane for all three. Code 1 uses two lanes for data only. Code 2 uses two lanes for address and data. Code 3 uses two lanes for all three. Code 5 uses four lanes for data only. Code 6 uses four lanes for address and data. Code 7 uses four lanes for all three.
- R4: When configuration bit 3 is set, an address phase follows the opcode phase. It sends 4 bytes when `addr4_i` is 1 and the low 3 bytes otherwise, most significant first, at the address lane width.
- R5: Configuration bits 6:4 give a count of dummy bytes. Each dummy byte takes 8 divided by the data lane width clocks, and all output enables stay low during these clocks.
- R6: When configuration bit 7 is set and bit 8 is clear, the sequencer sends (bits 16:9 plus one) bytes from the buffer. Byte k is byte k mod 4 of word k/4, where byte 0 is bits 7:0. Each byte goes out most significant first at the data lane width.
- R7: When bits 7 and 8 are both set, the sequencer reads the same number of bytes with all output enables low. It samples `io_i[1]` in single-lane mode, `io_i[1:0]` in dual mode and `io_i[3:0]` in quad mode on each rising clock edge. The bytes are stored into the buffer with the same byte order as R6.
- R8: Configuration bits 2:1 select which bit of `cs_n_o` goes low for the whole command. The other chip selects stay high.
- R9: Mode 0 timing applies. The serial clock is low whenever every chip select is high, and the lane outputs change only together with a falling clock edge while a command runs.
- R10: A write to the configuration register while a command runs has no effect. Writes to the opcode or address register during a command do not change the command in progress.
- R11: After reset, every chip select is high, the clock is low, all output enables are low and the configuration register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr4_i | input | 1 | Address length strap: 1 selects 4 bytes, 0 selects 3 bytes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| cs_n_o | output | 4 | Active-low chip selects |
| sclk_o | output | 1 | Serial clock |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
The hardest case to reach is a command whose every phase uses a different lane width, with dummy clocks counted at the data width in between. Only then does a wrong phase boundary shift the whole stream and show up in the captured data. The stimulus table walks all seven I/O modes with mixed dummy counts and both address lengths. It compares every captured clock against a stream rebuilt from R3, split by phase. A second hard case is a configuration write that arrives in the middle of a command. A directed run issues that write together with new opcode and address values after launch, then checks that the stream is unchanged and that no second command follows.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_END
    } phase_e;

    // lane width as log2(lanes): 0 = one lane, 1 = two, 2 = four
    typedef struct packed {
        logic [1:0] cmd_wl;
        logic [1:0] addr_wl;
        logic [1:0] data_wl;
    } lanes_t;

    localparam int          REG_AW  = 7;
    localparam logic [6:0]  RA_CFG  = 7'h00;
    localparam logic [6:0]  RA_OPC  = 7'h01;
    localparam logic [6:0]  RA_ADDR = 7'h02;

    function automatic logic [3:0] lane_mask(input logic [1:0] wl);
        case (wl)
            2'd0:    lane_mask = 4'b0001;
            2'd1:    lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/spi_seq_lane_dec.sv
module spi_seq_lane_dec
    import spi_seq_pkg::*;
(
    input  logic [2:0] mode_i,
    output lanes_t     lanes_o
);

    always_comb begin
        case (mode_i)
            3'd1:    lanes_o = '{cmd_wl: 2'd0, addr_wl: 2'd0, data_wl: 2'd1};
            3'd2:    lanes_o = '{cmd_wl: 2'd0, addr_wl: 2'd1, data_wl: 2'd1};
            3'd3:    lanes_o = '{cmd_wl: 2'd1, addr_wl: 2'd1, data_wl: 2'd1};
            3'd5:    lanes_o = '{cmd_wl: 2'd0, addr_wl: 2'd0, data_wl: 2'd2};
            3'd6:    lanes_o = '{cmd_wl: 2'd0, addr_wl: 2'd2, data_wl: 2'd2};
            3'd7:    lanes_o = '{cmd_wl: 2'd2, addr_wl: 2'd2, data_wl: 2'd2};
            default: lanes_o = '{cmd_wl: 2'd0, addr_wl: 2'd0, data_wl: 2'd0};
        endcase
    end

endmodule

// File: rtl/spi_seq_buf.sv
module spi_seq_buf #(
    parameter  int WORDS = 64,
    localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we_i,
    input  logic [IW-1:0] sw_idx_i,
    input  logic [31:0]   sw_wdata_i,
    output logic [31:0]   sw_rdata_o,
    input  logic [IW-1:0] eng_ridx_i,
    input  logic [1:0]    eng_rsel_i,
    output logic [7:0]    eng_rbyte_o,
    input  logic          eng_we_i,
    input  logic [IW-1:0] eng_widx_i,
    input  logic [1:0]    eng_wsel_i,
    input  logic [7:0]    eng_wbyte_i
);

    logic [31:0] mem_d [WORDS];
    logic [31:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (sw_we_i) mem_d[sw_idx_i] = sw_wdata_i;
        // the engine byte wins over a software word write to the same word
        if (eng_we_i) mem_d[eng_widx_i][eng_wsel_i*8 +: 8] = eng_wbyte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign sw_rdata_o  = mem_q[sw_idx_i];
    assign eng_rbyte_o = mem_q[eng_ridx_i][eng_rsel_i*8 +: 8];

    AST_READ_BYTE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we_i |=> mem_q[$past(eng_widx_i)][$past(eng_wsel_i)*8 +: 8] == $past(eng_wbyte_i)); // R7

endmodule

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq
    import spi_seq_pkg::*;
#(
    parameter int BUF_WORDS = 64,
    parameter int HALF_DIV  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr4_i,
    input  logic        reg_we_i,
    input  logic [6:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic [3:0]  cs_n_o,
    output logic        sclk_o,
    output logic [3:0]  io_o,
    output logic [3:0]  io_oe_o,
    input  logic [3:0]  io_i
);

    localparam int IW   = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        phase_e            ph;
        logic              sclk;
        logic [DIVW-1:0]   div;
        logic [5:0]        cnt;    // clocks left in the current unit
        logic [31:0]       sh;     // outgoing bits, MSB on the wire first
        logic [7:0]        rx;
        logic [7:0]        bidx;   // data byte in flight
        logic [19:1]       cfg;
        logic [7:0]        opc;
        logic [31:0]       addr;
        logic [31:0]       eaddr;  // address captured at launch
    } seq_t;

    seq_t   seq_d, seq_q;
    lanes_t run_l, new_l;
    logic [1:0]    wl;
    logic          busy, active, tick, rd_dir;
    logic [7:0]    fetch_idx, eng_byte;
    logic          eng_we;
    logic [31:0]   buf_rdata;

    spi_seq_lane_dec u_dec_run (.mode_i(seq_q.cfg[19:17]),   .lanes_o(run_l));
    spi_seq_lane_dec u_dec_new (.mode_i(reg_wdata_i[19:17]), .lanes_o(new_l));

    assign busy   = (seq_q.ph != ST_IDLE);
    assign active = (seq_q.ph == ST_CMD) || (seq_q.ph == ST_ADDR) ||
                    (seq_q.ph == ST_DUMMY) || (seq_q.ph == ST_DATA);
    assign tick   = (seq_q.div == DIVW'(HALF_DIV - 1));
    assign rd_dir = seq_q.cfg[8];
    assign wl     = (seq_q.ph == ST_CMD)  ? run_l.cmd_wl :
                    (seq_q.ph == ST_ADDR) ? run_l.addr_wl : run_l.data_wl;

    // next byte to present: the first one on entry, the following one inside
    assign fetch_idx = (seq_q.ph == ST_DATA) ? seq_q.bidx + 8'd1 : 8'd0;
    assign eng_we    = (seq_q.ph == ST_DATA) && rd_dir && tick && seq_q.sclk &&
                       (seq_q.cnt == 6'd1);

    spi_seq_buf #(.WORDS(BUF_WORDS)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we_i    (reg_we_i && reg_addr_i[6]),
        .sw_idx_i   (reg_addr_i[IW-1:0]),
        .sw_wdata_i (reg_wdata_i),
        .sw_rdata_o (buf_rdata),
        .eng_ridx_i (fetch_idx[IW+1:2]),
        .eng_rsel_i (fetch_idx[1:0]),
        .eng_rbyte_o(eng_byte),
        .eng_we_i   (eng_we),
        .eng_widx_i (seq_q.bidx[IW+1:2]),
        .eng_wsel_i (seq_q.bidx[1:0]),
        .eng_wbyte_i(seq_q.rx)
    );

    always_comb begin
        phase_e tgt;
        seq_d = seq_q;
        tgt   = ST_END;

        if (reg_we_i && reg_addr_i == RA_OPC)  seq_d.opc  = reg_wdata_i[7:0];
        if (reg_we_i && reg_addr_i == RA_ADDR) seq_d.addr = reg_wdata_i;

        if (!busy) begin
            if (reg_we_i && reg_addr_i == RA_CFG) begin
                seq_d.cfg = reg_wdata_i[19:1];
                if (reg_wdata_i[0]) begin
                    seq_d.ph    = ST_CMD;
                    seq_d.sclk  = 1'b0;
                    seq_d.div   = '0;
                    seq_d.sh    = {seq_q.opc, 24'h0};
                    seq_d.cnt   = 6'd8 >> new_l.cmd_wl;
                    seq_d.eaddr = seq_q.addr;
                    seq_d.rx    = '0;
                    seq_d.bidx  = '0;
                end
            end
        end else begin
            seq_d.div = tick ? '0 : seq_q.div + DIVW'(1);
            if (seq_q.ph == ST_END) begin
                if (tick) seq_d.ph = ST_IDLE;
            end else if (tick && !seq_q.sclk) begin
                seq_d.sclk = 1'b1;
                if (seq_q.ph == ST_DATA && rd_dir) begin
                    case (wl)
                        2'd0:    seq_d.rx = {seq_q.rx[6:0], io_i[1]};
                        2'd1:    seq_d.rx = {seq_q.rx[5:0], io_i[1:0]};
                        default: seq_d.rx = {seq_q.rx[3:0], io_i};
                    endcase
                end
            end else if (tick) begin
                seq_d.sclk = 1'b0;
                seq_d.cnt  = seq_q.cnt - 6'd1;
                case (wl)
                    2'd0:    seq_d.sh = {seq_q.sh[30:0], 1'b0};
                    2'd1:    seq_d.sh = {seq_q.sh[29:0], 2'b0};
                    default: seq_d.sh = {seq_q.sh[27:0], 4'b0};
                endcase
                if (seq_q.cnt == 6'd1) begin
                    case (seq_q.ph)
                        ST_CMD:   tgt = seq_q.cfg[3] ? ST_ADDR :
                                        (seq_q.cfg[6:4] != 3'd0) ? ST_DUMMY :
                                        seq_q.cfg[7] ? ST_DATA : ST_END;
                        ST_ADDR:  tgt = (seq_q.cfg[6:4] != 3'd0) ? ST_DUMMY :
                                        seq_q.cfg[7] ? ST_DATA : ST_END;
                        ST_DUMMY: tgt = seq_q.cfg[7] ? ST_DATA : ST_END;
                        default:  tgt = (seq_q.bidx == seq_q.cfg[16:9]) ? ST_END : ST_DATA;
                    endcase
                    seq_d.ph = tgt;
                    case (tgt)
                        ST_ADDR: begin
                            seq_d.sh  = addr4_i ? seq_q.eaddr : {seq_q.eaddr[23:0], 8'h0};
                            seq_d.cnt = (addr4_i ? 6'd32 : 6'd24) >> run_l.addr_wl;
                        end
                        ST_DUMMY: seq_d.cnt = {seq_q.cfg[6:4], 3'b000} >> run_l.data_wl;
                        ST_DATA: begin
                            seq_d.sh   = {eng_byte, 24'h0};
                            seq_d.cnt  = 6'd8 >> run_l.data_wl;
                            seq_d.bidx = fetch_idx;
                        end
                        default: seq_d.div = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign sclk_o = seq_q.sclk;
    assign cs_n_o = active ? ~(4'b0001 << seq_q.cfg[2:1]) : 4'hF;

    always_comb begin
        case (wl)
            2'd0:    io_o = {3'b000, seq_q.sh[31]};
            2'd1:    io_o = {2'b00, seq_q.sh[31:30]};
            default: io_o = seq_q.sh[31:28];
        endcase
        if (seq_q.ph == ST_CMD || seq_q.ph == ST_ADDR || (seq_q.ph == ST_DATA && !rd_dir))
            io_oe_o = lane_mask(wl);
        else
            io_oe_o = 4'b0000;
    end

    always_comb begin
        if (reg_addr_i == RA_CFG)       reg_rdata_o = {12'h0, seq_q.cfg, busy};
        else if (reg_addr_i == RA_OPC)  reg_rdata_o = {24'h0, seq_q.opc};
        else if (reg_addr_i == RA_ADDR) reg_rdata_o = seq_q.addr;
        else if (reg_addr_i[6])         reg_rdata_o = buf_rdata;
        else                            reg_rdata_o = '0;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R8
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n_o) && $past(!(&cs_n_o))) |-> $stable(cs_n_o)); // R8
    AST_SCLK_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n_o) |-> !sclk_o); // R9
    AST_LANES_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n_o) && $past(!(&cs_n_o)) && !$stable(io_o)) |-> $fell(sclk_o)); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(seq_q.cfg)); // R10
    AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&cs_n_o)); // R1

endmodule

// File: tb/spi_nor_cmd_seq_bench.sv
module spi_nor_cmd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr4 = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  ra = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdat;
    logic [3:0]  cs_n, io_o, io_oe, io_i;
    logic        sclk;

    always #10 clk = ~clk;

    spi_nor_cmd_seq u_spi_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .addr4_i(addr4),
        .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rdat),
        .cs_n_o(cs_n), .sclk_o(sclk), .io_o(io_o), .io_oe_o(io_oe), .io_i(io_i)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int k);
        return 4'(k * 5 + 9);
    endfunction

    // flash-side model: captures lanes at rising clock, presents read lanes after falling
    int n_rise = 0, n_fall = 0, base = 0, tviol = 0;
    logic [3:0] cap_v [512];
    logic [3:0] cap_oe [512];
    logic [3:0] cap_cs;
    assign io_i = pat(n_fall - base);

    always @(posedge sclk) begin
        if (n_rise - base < 512) begin
            cap_v[n_rise - base]  = io_o;
            cap_oe[n_rise - base] = io_oe;
        end
        if (n_rise == base) cap_cs = cs_n;
        n_rise++;
    end
    always @(negedge sclk) n_fall++;

    logic       prev_sclk = 1'b0;
    logic [3:0] prev_io = '0, prev_cs = 4'hF;
    always @(negedge clk) begin
        if (!(&cs_n) && !(&prev_cs) && io_o != prev_io && !(prev_sclk && !sclk)) tviol++;
        if ((&cs_n) && sclk) tviol++;
        prev_sclk = sclk; prev_io = io_o; prev_cs = cs_n;
    end

    // expected wire stream
    logic [3:0] ex_v [512];
    logic [3:0] ex_oe [512];
    int n_ex;

    task automatic push_bits(input logic [31:0] v, input int nbits, input int wl, input bit drive);
        int w;
        w = 1 << wl;
        for (int c = 0; c < nbits / w; c++) begin
            ex_v[n_ex]  = 4'((v >> (nbits - (c + 1) * w)) & ((1 << w) - 1));
            ex_oe[n_ex] = drive ? 4'((1 << w) - 1) : 4'h0;
            n_ex++;
        end
    endtask

    function automatic int diff(input int lo, input int hi);
        int d = 0;
        for (int i = lo; i < hi; i++)
            if (cap_oe[i] != ex_oe[i] || ((cap_v[i] ^ ex_v[i]) & ex_oe[i]) != 4'h0) d++;
        return d;
    endfunction

    // R3 lane width table, log2 of lanes; ph 0 opcode, 1 address, 2 data
    function automatic int wl_of(input logic [2:0] mode, input int ph);
        case (mode)
            3'd1: return (ph == 2) ? 1 : 0;
            3'd2: return (ph == 0) ? 0 : 1;
            3'd3: return 1;
            3'd5: return (ph == 2) ? 2 : 0;
            3'd6: return (ph == 0) ? 0 : 2;
            3'd7: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; ra = a; wd = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        ra = a; #1; d = rdat;
    endtask

    // {opcode, nbytes-1, rd, data_en, dummy, a4, addr_en, mode}
    localparam logic [25:0] VEC [10] = '{
        {8'h06, 8'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0},
        {8'h03, 8'd4, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 3'd0},
        {8'h3B, 8'd3, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 3'd1},
        {8'hBB, 8'd5, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 3'd2},
        {8'hA2, 8'd2, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 3'd3},
        {8'h6B, 8'd8, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 3'd5},
        {8'hEB, 8'd1, 1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 3'd6},
        {8'h32, 8'd7, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 3'd7},
        {8'h02, 8'd0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 3'd0},
        {8'h9F, 8'd2, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 3'd0}
    };

    task automatic run_cmd(input logic [25:0] v, input logic [1:0] sel, input bit poke, input int idx);
        logic [7:0]  op;
        logic [2:0]  mode, dum;
        logic        aen, a4, den, rdir;
        int          nb, wc, wa, wdt, s_a, s_d, s_x, s_e, rise0, tv0, cpb;
        logic [31:0] av, cfgw, r;
        logic [31:0] bm [4];
        logic [7:0]  eb [16];
        bit          done;

        op = v[25:18]; nb = int'(v[17:10]) + 1; rdir = v[9]; den = v[8];
        dum = v[7:5]; a4 = v[4]; aen = v[3]; mode = v[2:0];
        wc = wl_of(mode, 0); wa = wl_of(mode, 1); wdt = wl_of(mode, 2);
        addr4 = a4;
        av = 32'hC0DE_5A17 ^ (idx * 32'h1357_9BDF);
        for (int w = 0; w < 4; w++) begin
            bm[w] = (32'h8040_2010 * (idx + 1)) + w * 32'h0F1E_2D3C;
            wr(7'h40 + 7'(w), bm[w]);
        end
        wr(7'h01, {24'h0, op});
        wr(7'h02, av);

        n_ex = 0;
        push_bits({24'h0, op}, 8, wc, 1'b1);
        s_a = n_ex;
        if (aen) push_bits(av, a4 ? 32 : 24, wa, 1'b1);
        s_d = n_ex;
        push_bits(32'h0, int'(dum) * 8, wdt, 1'b0);
        s_x = n_ex;
        cpb = 8 >> wdt;
        if (den) begin
            for (int j = 0; j < nb; j++) begin
                if (!rdir) push_bits({24'h0, bm[j / 4][8 * (j % 4) +: 8]}, 8, wdt, 1'b1);
                else begin
                    eb[j] = 8'h0;
                    for (int c = 0; c < cpb; c++) begin
                        logic [3:0] p;
                        p = pat(s_x + j * cpb + c);
                        if (wdt == 0)      eb[j] = {eb[j][6:0], p[1]};
                        else if (wdt == 1) eb[j] = {eb[j][5:0], p[1:0]};
                        else               eb[j] = {eb[j][3:0], p};
                    end
                    push_bits(32'h0, 8, wdt, 1'b0);
                end
            end
        end
        s_e = n_ex;

        base = n_rise; tv0 = tviol;
        cfgw = {12'h0, mode, v[17:10], rdir, den, dum, aen, sel, 1'b1};
        wr(7'h00, cfgw);
        rd(7'h00, r);
        chk(r[0] == 1'b1, "R1", "start bit while running", r, 32'h1);
        if (poke) begin
            wr(7'h00, {12'h0, 3'd7, 8'd20, 1'b1, 1'b1, 3'd5, 1'b1, sel ^ 2'd1, 1'b1});
            wr(7'h01, 32'hFF);
            wr(7'h02, 32'hFFFF_FFFF);
        end
        done = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk);
            rd(7'h00, r);
            if (!r[0]) done = 1'b1;
        end
        chk(done && (&cs_n), "R1", "start bit cleared after command", {31'h0, r[0]}, 32'h0);
        rise0 = n_rise - base;
        chk(rise0 == s_e, "R2", "clock count of command", rise0, s_e);
        chk(diff(0, s_a) == 0, "R2", "opcode phase lanes", diff(0, s_a), 0);
        if (aen) chk(diff(s_a, s_d) == 0, "R4", "address phase lanes", diff(s_a, s_d), 0);
        if (dum != 0) chk(diff(s_d, s_x) == 0, "R5", "dummy clocks released lanes", diff(s_d, s_x), 0);
        if (den && !rdir) chk(diff(s_x, s_e) == 0, "R6", "write data lanes", diff(s_x, s_e), 0);
        if (den && rdir) begin
            chk(diff(s_x, s_e) == 0, "R7", "read phase released lanes", diff(s_x, s_e), 0);
            for (int j = 0; j < nb; j++) begin
                rd(7'h40 + 7'(j / 4), r);
                chk(r[8 * (j % 4) +: 8] == eb[j], "R7", "read byte in buffer",
                    r[8 * (j % 4) +: 8], eb[j]);
            end
        end
        chk(cap_cs == ~(4'b0001 << sel), "R8", "chip select during command", cap_cs, ~(4'b0001 << sel));
        chk(tviol == tv0, "R9", "lane changes only at falling clock", tviol - tv0, 0);
        if (poke) begin
            rd(7'h00, r);
            chk(r == (cfgw & ~32'h1), "R10", "config kept after busy write", r, cfgw & ~32'h1);
            repeat (40) @(negedge clk);
            chk((&cs_n) && (n_rise - base == rise0), "R10", "no second command launched",
                {28'h0, cs_n}, 32'hF);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rd(7'h00, r);
        chk(cs_n == 4'hF, "R11", "reset chip selects", {28'h0, cs_n}, 32'hF);
        chk(sclk == 1'b0 && io_oe == 4'h0, "R11", "reset clock and enables",
            {27'h0, sclk, io_oe}, 32'h0);
        chk(r == 32'h0, "R11", "reset config readback", r, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VEC[i]) run_cmd(VEC[i], 2'(i), 1'b0, i);

        // mid-command writes to config, opcode and address
        run_cmd(VEC[5], 2'd2, 1'b1, 20);
        run_cmd(VEC[4], 2'd1, 1'b1, 21);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule